// File: doc/BRIEF.md
# Bit-Oriented Frame Transmitter with Byte Queue

This block turns bytes written by a processor into a bit-synchronous HDLC-style frame on a single serial line. Bytes enter a small queue together with a per-byte end-of-message marker. Once a byte is waiting, the engine begins a frame on the next bit-clock enable without any software request. It first sends the 0x7E flag. It then sends the payload least significant bit first, with a zero inserted after every run of five ones. The frame check sequence and a closing flag follow. If the queue runs dry in the middle of a frame, the frame is closed anyway and the condition is recorded.

Line coding can be plain NRZ or NRZI. In NRZI mode the line is pinned high while no frame is in progress. A request-to-send output follows a software request. A release of that request is held off until the closing flag has fully left the line. The queue raises an interrupt at one of two selectable fill levels. Two status latches report the end of a message and an underrun. Both latches clear themselves when the next frame begins.

Top module: `hdlc_tx_engine`

## Requirements
- R1: The queue holds 4 entries; `fifo_full` is 1 when all 4 are occupied, and a write presented while full is discarded and never transmitted.
- R2: With `irq_sel`=0, `fifo_irq` is 1 exactly when the queue is empty; with `irq_sel`=1, it is 1 whenever at least one entry is free.
- R3: While idle, each bit enable sends a 1. On a bit enable that finds the queue non-empty, the engine starts a frame with the flag 0x7E, sent least significant bit first (bits 0,1,1,1,1,1,1,0). The line changes in the clock cycle after the enable.
- R4: Payload bytes are sent least significant bit first. A 0 is inserted after five consecutive 1s in payload and check sequence, counting across byte boundaries and into the check sequence. This includes an insertion just before the closing flag. Flags are never stuffed.
- R5: After the last byte, the engine sends the 16-bit check sequence of polynomial x^16+x^12+x^5+1. It is computed least significant bit first with reflected constant 0x8408, preset to 0xFFFF, complemented, and sent bit 0 first. A 0x7E closing flag follows.
- R6: A byte written with `wr_eom`=1 is the last byte of its frame. `eom_stat` becomes 1 when the check sequence starts.
- R7: If the queue is empty when a byte without the marker finishes, the frame is closed with check sequence and flag. Both `eom_stat` and `urun_stat` become 1.
- R8: Both status latches return to 0 when the next frame begins.
- R9: If the queue holds data when the last closing-flag bit is sent, the next frame's opening flag follows with no idle bit between.
- R10: `rts` rises the cycle after `rts_req` goes to 1. After `rts_req` falls, `rts` drops only on the first bit enable that finds no frame in progress. It therefore stays high throughout the last closing-flag bit period.
- R11: With `nrzi_en`=1, a 0 bit toggles `txd` and a 1 bit holds it. On every idle bit enable, `txd` is forced to 1.
- R12: After reset, `txd`=1, `rts`=0, `fifo_full`=0, both status latches are 0, and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write a byte into the queue |
| wr_data | input | 8 | Byte to queue |
| wr_eom | input | 1 | Marks the written byte as last of its frame |
| fifo_full | output | 1 | Queue has no free entry |
| fifo_irq | output | 1 | Queue level interrupt |
| irq_sel | input | 1 | 0: interrupt on empty, 1: interrupt on any free entry |
| bit_en | input | 1 | One-cycle bit clock enable |
| nrzi_en | input | 1 | Select NRZI line coding |
| rts_req | input | 1 | Software request-to-send |
| txd | output | 1 | Serial line |
| rts | output | 1 | Request-to-send output |
| eom_stat | output | 1 | End-of-message / underrun latch |
| urun_stat | output | 1 | Frame was closed by underrun |

## Verification
The bench sweeps every byte value inside long frames and recomputes the stuffed bit stream, check sequence and NRZI levels arithmetically. A design that reset the ones counter at byte boundaries, or skipped a stuff bit just before the closing flag, would disagree within a few bits. Back-to-back frames and an underrun frame are also driven. Inserting an idle bit between frames, or failing to close a starved frame, would shift the whole stream. The bench drops the send request mid-frame and then checks `rts` on the exact last flag bit and on the following enable, which catches a release one bit early. The queue is filled to the brim with a surplus write. A design that stored the extra byte would start a spurious second frame during the idle bits.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam int          BYTE_BITS  = 8;
    localparam int          FCS_BITS   = 16;
    localparam int          CNT_W      = $clog2(FCS_BITS);
    localparam int          ONES_LIMIT = 5;
    localparam logic [7:0]  FLAG_OCTET = 8'h7E;
    localparam logic [15:0] CRC_PRESET = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_R = 16'h8408;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_DATA,
        ST_FCS,
        ST_CLOSE
    } fr_state_t;

    typedef struct packed {
        logic       eom;
        logic [7:0] data;
    } tx_entry_t;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return {1'b0, c[15:1]} ^ (fb ? CRC_POLY_R : 16'h0000);
    endfunction

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] push_data,
    input  logic       push_eom,
    input  logic       pop,
    input  logic       irq_sel,
    output logic [7:0] head_data,
    output logic       head_eom,
    output logic       empty,
    output logic       full,
    output logic       irq
);
    import hdlc_tx_pkg::*;

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    typedef struct packed {
        tx_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]         wp;
        logic [PW-1:0]         rp;
        logic [CW-1:0]         cnt;
    } fifo_regs_t;

    fifo_regs_t fq_q, fq_d;
    logic       do_push, do_pop;

    always_comb begin
        fq_d    = fq_q;
        do_push = push && (fq_q.cnt != CNT_FULL);
        do_pop  = pop && (fq_q.cnt != '0);
        if (do_push) begin
            fq_d.mem[fq_q.wp] = '{eom: push_eom, data: push_data};
            fq_d.wp = (fq_q.wp == PTR_LAST) ? '0 : fq_q.wp + 1'b1;
        end
        if (do_pop) begin
            fq_d.rp = (fq_q.rp == PTR_LAST) ? '0 : fq_q.rp + 1'b1;
        end
        unique case ({do_push, do_pop})
            2'b10:   fq_d.cnt = fq_q.cnt + 1'b1;
            2'b01:   fq_d.cnt = fq_q.cnt - 1'b1;
            default: fq_d.cnt = fq_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fq_q <= '0;
        else        fq_q <= fq_d;
    end

    assign head_data = fq_q.mem[fq_q.rp].data;
    assign head_eom  = fq_q.mem[fq_q.rp].eom;
    assign empty     = (fq_q.cnt == '0);
    assign full      = (fq_q.cnt == CNT_FULL);
    assign irq       = irq_sel ? !full : empty;

    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);  // R6
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);  // R1

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       fifo_empty,
    input  logic [7:0] head_data,
    input  logic       head_eom,
    output logic       fifo_pop,
    output logic       line_bit,
    output logic       line_idle,
    output logic       frame_active,
    output logic       eom_lat,
    output logic       urun_lat
);
    import hdlc_tx_pkg::*;

    localparam logic [CNT_W-1:0] CNT_BYTE  = CNT_W'(BYTE_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_FCS   = CNT_W'(FCS_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_FIRST = CNT_W'(BYTE_BITS - 2);
    localparam logic [2:0]       RUN_MAX   = 3'(ONES_LIMIT);

    typedef struct packed {
        fr_state_t        st;
        logic [7:0]       sh;
        logic [15:0]      fcs;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       ones;
        logic             eom_pend;
        logic             eom_lat;
        logic             urun_lat;
    } fr_regs_t;

    fr_regs_t    fr_q, fr_d;
    logic [15:0] crc_nx;

    always_comb begin
        fr_d      = fr_q;
        fifo_pop  = 1'b0;
        line_bit  = 1'b1;
        line_idle = 1'b0;
        crc_nx    = crc_step(fr_q.fcs, fr_q.sh[0]);
        if (bit_en) begin
            unique case (fr_q.st)
                ST_IDLE: begin
                    if (fifo_empty) begin
                        line_idle = 1'b1;
                    end else begin
                        line_bit      = FLAG_OCTET[0];
                        fr_d.st       = ST_OPEN;
                        fr_d.sh       = {1'b0, FLAG_OCTET[7:1]};
                        fr_d.cnt      = CNT_FIRST;
                        fr_d.ones     = '0;
                        fr_d.fcs      = CRC_PRESET;
                        fr_d.eom_lat  = 1'b0;
                        fr_d.urun_lat = 1'b0;
                    end
                end
                ST_OPEN: begin
                    line_bit = fr_q.sh[0];
                    fr_d.sh  = {1'b0, fr_q.sh[7:1]};
                    if (fr_q.cnt == '0) begin
                        fifo_pop      = 1'b1;
                        fr_d.sh       = head_data;
                        fr_d.eom_pend = head_eom;
                        fr_d.cnt      = CNT_BYTE;
                        fr_d.st       = ST_DATA;
                    end else begin
                        fr_d.cnt = fr_q.cnt - 1'b1;
                    end
                end
                ST_DATA: begin
                    if (fr_q.ones == RUN_MAX) begin
                        line_bit  = 1'b0;
                        fr_d.ones = '0;
                    end else begin
                        line_bit  = fr_q.sh[0];
                        fr_d.sh   = {1'b0, fr_q.sh[7:1]};
                        fr_d.fcs  = crc_nx;
                        fr_d.ones = fr_q.sh[0] ? fr_q.ones + 3'd1 : 3'd0;
                        if (fr_q.cnt == '0) begin
                            if (fr_q.eom_pend || fifo_empty) begin
                                fr_d.st       = ST_FCS;
                                fr_d.fcs      = ~crc_nx;
                                fr_d.cnt      = CNT_FCS;
                                fr_d.eom_lat  = 1'b1;
                                fr_d.urun_lat = !fr_q.eom_pend;
                            end else begin
                                fifo_pop      = 1'b1;
                                fr_d.sh       = head_data;
                                fr_d.eom_pend = head_eom;
                                fr_d.cnt      = CNT_BYTE;
                            end
                        end else begin
                            fr_d.cnt = fr_q.cnt - 1'b1;
                        end
                    end
                end
                ST_FCS: begin
                    if (fr_q.ones == RUN_MAX) begin
                        line_bit  = 1'b0;
                        fr_d.ones = '0;
                    end else begin
                        line_bit  = fr_q.fcs[0];
                        fr_d.fcs  = {1'b0, fr_q.fcs[15:1]};
                        fr_d.ones = fr_q.fcs[0] ? fr_q.ones + 3'd1 : 3'd0;
                        if (fr_q.cnt == '0) begin
                            fr_d.st  = ST_CLOSE;
                            fr_d.sh  = FLAG_OCTET;
                            fr_d.cnt = CNT_BYTE;
                        end else begin
                            fr_d.cnt = fr_q.cnt - 1'b1;
                        end
                    end
                end
                ST_CLOSE: begin
                    if (fr_q.ones == RUN_MAX) begin
                        line_bit  = 1'b0;
                        fr_d.ones = '0;
                    end else begin
                        line_bit  = fr_q.sh[0];
                        fr_d.sh   = {1'b0, fr_q.sh[7:1]};
                        fr_d.ones = '0;
                        if (fr_q.cnt == '0) begin
                            if (!fifo_empty) begin
                                fr_d.st       = ST_OPEN;
                                fr_d.sh       = FLAG_OCTET;
                                fr_d.cnt      = CNT_BYTE;
                                fr_d.fcs      = CRC_PRESET;
                                fr_d.eom_lat  = 1'b0;
                                fr_d.urun_lat = 1'b0;
                            end else begin
                                fr_d.st = ST_IDLE;
                            end
                        end else begin
                            fr_d.cnt = fr_q.cnt - 1'b1;
                        end
                    end
                end
                default: fr_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q     <= '0;
            fr_q.st  <= ST_IDLE;
            fr_q.fcs <= CRC_PRESET;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign frame_active = (fr_q.st != ST_IDLE);
    assign eom_lat      = fr_q.eom_lat;
    assign urun_lat     = fr_q.urun_lat;

    AST_FLAG_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && fr_q.st == ST_OPEN) |-> (fr_q.ones == 3'd0));  // R4
    AST_LATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && fr_q.st == ST_IDLE && !fifo_empty) |=> (!eom_lat && !urun_lat));  // R8
    AST_URUN_IS_EOM: assert property (@(posedge clk) disable iff (!rst_n)
        urun_lat |-> eom_lat);  // R7

endmodule

// File: rtl/hdlc_tx_line.sv
module hdlc_tx_line (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic line_bit,
    input  logic line_idle,
    input  logic frame_active,
    input  logic nrzi_en,
    input  logic rts_req,
    output logic txd,
    output logic rts
);
    typedef struct packed {
        logic txd;
        logic rts;
    } line_regs_t;

    line_regs_t ln_q, ln_d;

    always_comb begin
        ln_d = ln_q;
        if (bit_en) begin
            if (line_idle)    ln_d.txd = 1'b1;
            else if (nrzi_en) ln_d.txd = line_bit ? ln_q.txd : ~ln_q.txd;
            else              ln_d.txd = line_bit;
        end
        if (rts_req)                      ln_d.rts = 1'b1;
        else if (bit_en && !frame_active) ln_d.rts = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '{txd: 1'b1, rts: 1'b0};
        else        ln_q <= ln_d;
    end

    assign txd = ln_q.txd;
    assign rts = ln_q.rts;

    AST_RTS_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_active && rts) |=> rts);  // R10
    AST_IDLE_MARK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && line_idle) |=> txd);  // R11

endmodule

// File: rtl/hdlc_tx_engine.sv
module hdlc_tx_engine #(
    parameter int FIFO_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wr_eom,
    output logic       fifo_full,
    output logic       fifo_irq,
    input  logic       irq_sel,
    input  logic       bit_en,
    input  logic       nrzi_en,
    input  logic       rts_req,
    output logic       txd,
    output logic       rts,
    output logic       eom_stat,
    output logic       urun_stat
);
    logic       fifo_empty;
    logic       fifo_pop;
    logic [7:0] head_data;
    logic       head_eom;
    logic       line_bit;
    logic       line_idle;
    logic       frame_active;

    hdlc_tx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (wr_data),
        .push_eom  (wr_eom),
        .pop       (fifo_pop),
        .irq_sel   (irq_sel),
        .head_data (head_data),
        .head_eom  (head_eom),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .irq       (fifo_irq)
    );

    hdlc_tx_framer u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .fifo_empty   (fifo_empty),
        .head_data    (head_data),
        .head_eom     (head_eom),
        .fifo_pop     (fifo_pop),
        .line_bit     (line_bit),
        .line_idle    (line_idle),
        .frame_active (frame_active),
        .eom_lat      (eom_stat),
        .urun_lat     (urun_stat)
    );

    hdlc_tx_line u_line (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .line_bit     (line_bit),
        .line_idle    (line_idle),
        .frame_active (frame_active),
        .nrzi_en      (nrzi_en),
        .rts_req      (rts_req),
        .txd          (txd),
        .rts          (rts)
    );

endmodule

// File: tb/hdlc_tx_engine_bench.sv
module hdlc_tx_engine_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_eom = 1'b0;
    logic       fifo_full, fifo_irq;
    logic       irq_sel = 1'b0;
    logic       bit_en = 1'b0;
    logic       nrzi_en = 1'b0;
    logic       rts_req = 1'b0;
    logic       txd, rts, eom_stat, urun_stat;

    always #5 clk = ~clk;

    hdlc_tx_engine u_hdlc_tx_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_eom(wr_eom),
        .fifo_full(fifo_full), .fifo_irq(fifo_irq), .irq_sel(irq_sel), .bit_en(bit_en),
        .nrzi_en(nrzi_en), .rts_req(rts_req), .txd(txd), .rts(rts),
        .eom_stat(eom_stat), .urun_stat(urun_stat)
    );

    localparam logic [7:0] FLAGV = 8'h7E;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int ones_m = 0;
    logic [8:0] pend[$];
    logic [1:0] expq[$];
    logic [7:0] cur[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic wr(input logic [8:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        {wr_eom, wr_data} = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(output logic t, output logic r);
        @(negedge clk);
        if (pend.size() > 0 && !fifo_full) begin
            wr_en = 1'b1;
            {wr_eom, wr_data} = pend.pop_front();
        end
        bit_en = 1'b1;
        @(negedge clk);
        wr_en  = 1'b0;
        bit_en = 1'b0;
        t = txd;
        r = rts;
    endtask

    task automatic exp_flag();
        for (int i = 0; i < 8; i++) expq.push_back({1'b0, FLAGV[i]});
    endtask

    task automatic exp_idle(input int n);
        for (int i = 0; i < n; i++) expq.push_back(2'b11);
    endtask

    task automatic exp_stuffed(input logic b);
        expq.push_back({1'b0, b});
        if (b) ones_m++;
        else   ones_m = 0;
        if (ones_m == 5) begin
            expq.push_back(2'b00);
            ones_m = 0;
        end
    endtask

    task automatic add_frame(input bit with_eom, input bit feed);
        logic [15:0] c;
        c = 16'hFFFF;
        ones_m = 0;
        exp_flag();
        for (int k = 0; k < cur.size(); k++) begin
            if (feed) pend.push_back({with_eom && (k == cur.size() - 1), cur[k]});
            for (int i = 0; i < 8; i++) begin
                logic b, fb;
                b  = cur[k][i];
                fb = c[0] ^ b;
                c  = c >> 1;
                if (fb) c = c ^ 16'h8408;
                exp_stuffed(b);
            end
        end
        c = ~c;
        for (int i = 0; i < 16; i++) exp_stuffed(c[i]);
        exp_flag();
        cur.delete();
    endtask

    task automatic run(input bit nrzi, input int rts_drop, input bit chk_clear,
                       input bit exp_urun, input string req);
        int bad, first, nframe;
        logic lvl, t, r, e;
        bad = 0; first = -1; nframe = 0; lvl = 1'b1;
        nrzi_en = nrzi;
        foreach (expq[i]) if (!expq[i][1]) nframe++;
        if (pend.size() > 0) wr(pend.pop_front());
        for (int i = 0; i < expq.size(); i++) begin
            if (i == rts_drop) rts_req = 1'b0;
            tick(t, r);
            if (expq[i][1]) begin
                lvl = 1'b1;
                e = 1'b1;
            end else if (nrzi) begin
                if (!expq[i][0]) lvl = ~lvl;
                e = lvl;
            end else begin
                e = expq[i][0];
            end
            if (t !== e) begin
                bad++;
                if (first < 0) first = i;
            end
            if (i == 0 && chk_clear)
                check(!eom_stat && !urun_stat, "R8", "latches cleared at frame start",
                      {eom_stat, urun_stat}, 0);
            if (rts_drop >= 0 && i == nframe - 1)
                check(r === 1'b1, "R10", "rts during last closing flag bit", r, 1);
            if (rts_drop >= 0 && i == nframe)
                check(r === 1'b0, "R10", "rts after closing flag", r, 0);
        end
        check(bad == 0, req, $sformatf("line bit mismatches, first at %0d", first), bad, 0);
        check(eom_stat === 1'b1, "R6", "end-of-message latch after frame", eom_stat, 1);
        check(urun_stat === exp_urun, "R7", "underrun latch after frame", urun_stat, exp_urun);
        expq.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic t, r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        check(txd === 1'b1, "R12", "txd after reset", txd, 1);
        check(rts === 1'b0, "R12", "rts after reset", rts, 0);
        check(fifo_full === 1'b0, "R12", "full after reset", fifo_full, 0);
        check(fifo_irq === 1'b1, "R12", "empty irq after reset", fifo_irq, 1);
        check(!eom_stat && !urun_stat, "R12", "latches after reset", {eom_stat, urun_stat}, 0);

        // R10 request follow and idle release
        rts_req = 1'b1;
        @(negedge clk);
        check(rts === 1'b1, "R10", "rts follows request", rts, 1);
        rts_req = 1'b0;
        repeat (3) @(negedge clk);
        check(rts === 1'b1, "R10", "rts held until bit enable", rts, 1);
        tick(t, r);
        check(r === 1'b0, "R10", "rts released on idle bit enable", r, 0);
        check(t === 1'b1, "R3", "idle line is mark", t, 1);

        // R1 R2 fill sweep, surplus write discarded
        for (int k = 0; k <= 4; k++) begin
            irq_sel = 1'b0;
            #1;
            check(fifo_irq === (k == 0), "R2", $sformatf("irq empty mode level %0d", k), fifo_irq, k == 0);
            irq_sel = 1'b1;
            #1;
            check(fifo_irq === (k < 4), "R2", $sformatf("irq free mode level %0d", k), fifo_irq, k < 4);
            check(fifo_full === (k == 4), "R1", $sformatf("full at level %0d", k), fifo_full, k == 4);
            if (k < 4) begin
                cur.push_back(8'(k * 71 + 9));
                wr({k == 3, 8'(k * 71 + 9)});
            end
        end
        wr({1'b1, 8'h55});
        check(fifo_full === 1'b1, "R1", "still full after surplus write", fifo_full, 1);
        add_frame(1'b1, 1'b0);
        exp_idle(12);
        run(1'b0, -1, 1'b0, 1'b0, "R1");
        irq_sel = 1'b0;
        #1;
        check(fifo_irq === 1'b1, "R2", "empty after frame", fifo_irq, 1);

        // R3 frame lengths with both codings
        for (int len = 1; len <= 4; len++) begin
            for (int k = 0; k < len; k++) cur.push_back(8'(len * 53 + k * 29 + 1));
            add_frame(1'b1, 1'b1);
            exp_idle(4);
            run(len[0], -1, 1'b1, 1'b0, "R3");
        end

        // R4 long runs of ones and flag-like payload
        repeat (3) cur.push_back(8'hFF);
        cur.push_back(8'h7E);
        cur.push_back(8'h1F);
        add_frame(1'b1, 1'b1);
        exp_idle(4);
        run(1'b0, -1, 1'b1, 1'b0, "R4");

        // R5 every byte value, plain coding
        for (int v = 0; v < 256; v++) cur.push_back(8'(v));
        add_frame(1'b1, 1'b1);
        exp_idle(4);
        run(1'b0, -1, 1'b1, 1'b0, "R5");

        // R11 every byte value reversed, NRZI with idle forced high
        for (int v = 255; v >= 0; v--) cur.push_back(8'(v));
        add_frame(1'b1, 1'b1);
        exp_idle(4);
        run(1'b1, -1, 1'b1, 1'b0, "R11");
        check(txd === 1'b1, "R11", "NRZI idle line high", txd, 1);

        // R7 underrun closes frame
        cur.push_back(8'hA5);
        cur.push_back(8'hFF);
        cur.push_back(8'h3C);
        add_frame(1'b0, 1'b1);
        exp_idle(4);
        run(1'b0, -1, 1'b1, 1'b1, "R7");

        // R9 back-to-back frames, R10 release after final closing flag
        rts_req = 1'b1;
        cur.push_back(8'hF8);
        cur.push_back(8'h0F);
        add_frame(1'b1, 1'b1);
        cur.push_back(8'hFF);
        cur.push_back(8'h81);
        cur.push_back(8'hFE);
        add_frame(1'b1, 1'b1);
        exp_idle(4);
        run(1'b1, 10, 1'b1, 1'b0, "R9");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule